// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Arbitration

This block is a word-addressed memory reachable from two symmetric ports, left and right. Each port has its own address, write data, active-low select, active-low read enable and active-low write strobe, and the two ports run side by side in one clock domain. A port that is selected with its read enable low returns the addressed word one cycle later. A port that is selected with its write strobe low stores its word at the clock edge.

When both ports are selected on the same address, an arbiter picks one of them. The winner is the port whose select and address were already held from the cycle before. If both ports arrive in the same cycle, the left port wins. The losing port's write is dropped, and in the next cycle the losing port's active-low busy flag goes low. Reads are never blocked.

A build parameter chooses the busy behaviour. In master mode the busy outputs come from the arbiter and the external busy inputs are ignored. In slave mode the arbiter is left out: each port's external busy input, when low, suppresses that port's write, and the busy outputs stay high. This lets a master and one or more slaves share address and control lines to build a wider word.

Top module: `dpram_arb`

## Requirements
- R1: The memory holds 2**ADDR_W words of DATA_W bits (2048 x 8 by default). A port with cs_n=0 and we_n=0 stores wdata at addr on the clock edge. A port with cs_n=0 and oe_n=0 presents the word at addr on rdata after that edge; in that cycle the read returns the value held before any write made at the same edge.
- R2: A port with cs_n=1 stores nothing, whatever its write strobe. Its rdata is 0 after the edge. A selected port with oe_n=1 also shows rdata 0.
- R3: Two selected ports on different addresses both read and write with no blocking, and both busy outputs stay high.
- R4: Master mode: when both selected ports present the same address, only the winner's write is stored.
- R5: Master mode: if one port was selected on the same address in the previous cycle and the other port is newly arriving, the earlier port wins. The winner is kept for as long as both ports hold their selects and addresses.
- R6: Master mode: if both ports arrive on the same address in the same cycle, the left port wins.
- R7: Master mode: the loser's busy_n is low after the edge at which the match is seen. It returns high after the first edge at which the addresses differ or either port is deselected. The two busy_n outputs are never low together.
- R8: Reads from both ports to one address both return the stored word, and busy_n is still driven low on the loser.
- R9: Slave mode: busy_n outputs stay high. A low busy_in_n suppresses that port's write and leaves its reads intact. Writes from both ports to the same address are not arbitrated, and the left port's data is the one stored.
- R10: Master mode ignores busy_in_n on both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_cs_n | input | 1 | Left select, active low |
| l_oe_n | input | 1 | Left read enable, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_busy_in_n | input | 1 | Left external write inhibit, active low (slave mode) |
| l_rdata | output | DATA_W | Left read data |
| l_busy_n | output | 1 | Left lost arbitration, active low (master mode) |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_cs_n | input | 1 | Right select, active low |
| r_oe_n | input | 1 | Right read enable, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_busy_in_n | input | 1 | Right external write inhibit, active low (slave mode) |
| r_rdata | output | DATA_W | Right read data |
| r_busy_n | output | 1 | Right lost arbitration, active low (master mode) |

## Verification
The hardest case to reach is a staggered arrival. One port must sit on an address for a full cycle, and the other must then join it with a write, so that the rule favouring the earlier port decides, not the tie-break. The stimulus holds a read on one port and then brings a write onto the same address from the other. It keeps both ports in place for another cycle to confirm the winner does not change, then deselects both to watch busy_n release. The same sequence is run again with the roles swapped. A master and a slave instance receive identical stimulus, so the effect of blocking shows up as a difference between two reference memories.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
   typedef enum logic [0:0] {
      SIDE_LEFT  = 1'b0,
      SIDE_RIGHT = 1'b1
   } side_e;
endpackage

// File: rtl/dpram_arbiter.sv
module dpram_arbiter
   import dpram_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_act,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              r_act,
   input  logic [ADDR_W-1:0] r_addr,
   output logic              l_lose,
   output logic              r_lose,
   output logic              l_busy_q,
   output logic              r_busy_q
);
   logic              l_act_q, r_act_q;
   logic [ADDR_W-1:0] l_addr_q, r_addr_q;
   side_e             owner_q, win;
   logic              match, l_stable, r_stable;

   assign match    = l_act && r_act && (l_addr == r_addr);
   assign l_stable = l_act && l_act_q && (l_addr == l_addr_q);
   assign r_stable = r_act && r_act_q && (r_addr == r_addr_q);

   always_comb begin
      unique case ({l_stable, r_stable})
         2'b11:   win = owner_q;
         2'b01:   win = SIDE_RIGHT;
         default: win = SIDE_LEFT;
      endcase
   end

   assign l_lose = match && (win == SIDE_RIGHT);
   assign r_lose = match && (win == SIDE_LEFT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l_act_q  <= 1'b0;
         r_act_q  <= 1'b0;
         l_addr_q <= '0;
         r_addr_q <= '0;
         owner_q  <= SIDE_LEFT;
         l_busy_q <= 1'b0;
         r_busy_q <= 1'b0;
      end else begin
         l_act_q  <= l_act;
         r_act_q  <= r_act;
         l_addr_q <= l_addr;
         r_addr_q <= r_addr;
         owner_q  <= win;
         l_busy_q <= l_lose;
         r_busy_q <= r_lose;
      end
   end

   AST_BUSY_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
      !(l_busy_q && r_busy_q)); // R7
   AST_EARLY_LEFT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (match && $past(l_act) && !$past(r_act) && $stable(l_addr)) |-> r_lose); // R5
   AST_EARLY_RIGHT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (match && $past(r_act) && !$past(l_act) && $stable(r_addr)) |-> l_lose); // R5
   AST_OWNER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (match && $past(match) && $stable(l_addr) && $stable(r_addr))
         |-> (l_lose == $past(l_lose))); // R5
endmodule

// File: rtl/dpram_port.sv
module dpram_port #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              block,
   input  logic [DATA_W-1:0] mem_rd,
   output logic              wr_en,
   output logic [DATA_W-1:0] rdata
);
   assign wr_en = !cs_n && !we_n && !block;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              rdata <= '0;
      else if (!cs_n && !oe_n) rdata <= mem_rd;
      else                     rdata <= '0;
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs_n) |-> (rdata == '0)); // R2
   AST_NO_READ_EN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(oe_n) |-> (rdata == '0)); // R2
endmodule

// File: rtl/dpram_arb.sv
module dpram_arb #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8,
   parameter bit MASTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   input  logic              l_cs_n,
   input  logic              l_oe_n,
   input  logic              l_we_n,
   input  logic              l_busy_in_n,
   output logic [DATA_W-1:0] l_rdata,
   output logic              l_busy_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   input  logic              r_cs_n,
   input  logic              r_oe_n,
   input  logic              r_we_n,
   input  logic              r_busy_in_n,
   output logic [DATA_W-1:0] r_rdata,
   output logic              r_busy_n
);
   localparam int DEPTH = 2 ** ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("dpram_arb: ADDR_W must lie in 1..12");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("dpram_arb: DATA_W must be positive");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic              l_block, r_block, l_we, r_we;

   if (MASTER) begin : g_master
      logic l_lose, r_lose, l_busy_q, r_busy_q;
      dpram_arbiter #(.ADDR_W(ADDR_W)) u_arb (
         .clk      (clk),
         .rst_n    (rst_n),
         .l_act    (!l_cs_n),
         .l_addr   (l_addr),
         .r_act    (!r_cs_n),
         .r_addr   (r_addr),
         .l_lose   (l_lose),
         .r_lose   (r_lose),
         .l_busy_q (l_busy_q),
         .r_busy_q (r_busy_q)
      );
      assign l_block  = l_lose;
      assign r_block  = r_lose;
      assign l_busy_n = !l_busy_q;
      assign r_busy_n = !r_busy_q;

      AST_NO_SHARED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         !(l_we && r_we && (l_addr == r_addr))); // R4
      AST_BUSY_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
         (l_busy_n || r_busy_n)); // R7
   end else begin : g_slave
      assign l_block  = !l_busy_in_n;
      assign r_block  = !r_busy_in_n;
      assign l_busy_n = 1'b1;
      assign r_busy_n = 1'b1;

      AST_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         (!l_busy_in_n |-> !l_we) and (!r_busy_in_n |-> !r_we)); // R9
   end

   dpram_port #(.DATA_W(DATA_W)) u_left (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs_n   (l_cs_n),
      .oe_n   (l_oe_n),
      .we_n   (l_we_n),
      .block  (l_block),
      .mem_rd (mem[l_addr]),
      .wr_en  (l_we),
      .rdata  (l_rdata)
   );

   dpram_port #(.DATA_W(DATA_W)) u_right (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs_n   (r_cs_n),
      .oe_n   (r_oe_n),
      .we_n   (r_we_n),
      .block  (r_block),
      .mem_rd (mem[r_addr]),
      .wr_en  (r_we),
      .rdata  (r_rdata)
   );

   // Right first, so a same-address write from the left takes precedence (R9).
   always_ff @(posedge clk) begin
      if (r_we) mem[r_addr] <= r_wdata;
      if (l_we) mem[l_addr] <= l_wdata;
   end
endmodule

// File: tb/dpram_arb_tb.sv
module dpram_arb_tb;
   localparam int CLK_P = 10;
   localparam int AW    = 4;
   localparam int DW    = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] l_addr, r_addr;
   logic [DW-1:0] l_wd, r_wd;
   logic          l_cs, l_oe, l_we, l_bin, r_cs, r_oe, r_we, r_bin;
   logic [DW-1:0] m_lrd, m_rrd, s_lrd, s_rrd;
   logic          m_lbz, m_rbz, s_lbz, s_rbz;
   logic [DW-1:0] ref_m [16];
   logic [DW-1:0] ref_s [16];
   int            n_chk = 0, n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   dpram_arb #(.ADDR_W(AW), .DATA_W(DW), .MASTER(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .l_addr(l_addr), .l_wdata(l_wd), .l_cs_n(l_cs), .l_oe_n(l_oe), .l_we_n(l_we),
      .l_busy_in_n(l_bin), .l_rdata(m_lrd), .l_busy_n(m_lbz),
      .r_addr(r_addr), .r_wdata(r_wd), .r_cs_n(r_cs), .r_oe_n(r_oe), .r_we_n(r_we),
      .r_busy_in_n(r_bin), .r_rdata(m_rrd), .r_busy_n(m_rbz));

   dpram_arb #(.ADDR_W(AW), .DATA_W(DW), .MASTER(1'b0)) u_dut_slave (
      .clk(clk), .rst_n(rst_n),
      .l_addr(l_addr), .l_wdata(l_wd), .l_cs_n(l_cs), .l_oe_n(l_oe), .l_we_n(l_we),
      .l_busy_in_n(l_bin), .l_rdata(s_lrd), .l_busy_n(s_lbz),
      .r_addr(r_addr), .r_wdata(r_wd), .r_cs_n(r_cs), .r_oe_n(r_oe), .r_we_n(r_we),
      .r_busy_in_n(r_bin), .r_rdata(s_rrd), .r_busy_n(s_rbz));

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // cs, oe, we are active low
   task automatic drv_l(input logic cs, input logic oe, input logic we,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
      l_cs = cs; l_oe = oe; l_we = we; l_addr = a; l_wd = d;
   endtask
   task automatic drv_r(input logic cs, input logic oe, input logic we,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
      r_cs = cs; r_oe = oe; r_we = we; r_addr = a; r_wd = d;
   endtask

   task automatic busy_chk(input string tag, input logic ml, input logic mr);
      chk({tag, " master left busy_n"},  {7'd0, m_lbz}, {7'd0, ml});
      chk({tag, " master right busy_n"}, {7'd0, m_rbz}, {7'd0, mr});
      chk({tag, " slave left busy_n"},   {7'd0, s_lbz}, 8'd1);
      chk({tag, " slave right busy_n"},  {7'd0, s_rbz}, 8'd1);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #(CLK_P * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      l_bin = 1'b1; r_bin = 1'b1;
      drv_l(1'b1, 1'b1, 1'b1, '0, '0);
      drv_r(1'b1, 1'b1, 1'b1, '0, '0);
      tick(); tick();
      rst_n = 1'b1;
      tick();
      chk("R2 reset left rdata",  m_lrd, 8'h00);
      chk("R2 reset right rdata", m_rrd, 8'h00);
      busy_chk("R7 reset", 1'b1, 1'b1);

      // R1/R3: simultaneous writes on distinct addresses fill the array
      for (int i = 0; i < 8; i++) begin
         drv_l(1'b0, 1'b1, 1'b0, AW'(i),     DW'(i * 17 + 1));
         drv_r(1'b0, 1'b1, 1'b0, AW'(i + 8), DW'(i * 29 + 5));
         ref_m[i] = DW'(i * 17 + 1);  ref_s[i] = DW'(i * 17 + 1);
         ref_m[i+8] = DW'(i * 29 + 5); ref_s[i+8] = DW'(i * 29 + 5);
         tick();
         busy_chk("R3 distinct writes", 1'b1, 1'b1);
      end
      // R1/R3: read back every address from both ports at once
      for (int i = 0; i < 16; i++) begin
         drv_l(1'b0, 1'b0, 1'b1, AW'(i),      '0);
         drv_r(1'b0, 1'b0, 1'b1, AW'(15 - i), '0);
         tick();
         chk("R1 master left read",  m_lrd, ref_m[i]);
         chk("R3 master right read", m_rrd, ref_m[15 - i]);
         chk("R1 slave left read",   s_lrd, ref_s[i]);
         chk("R3 slave right read",  s_rrd, ref_s[15 - i]);
      end

      // R2: deselected write is ignored, deselected / oe-high port reads zero
      drv_r(1'b1, 1'b1, 1'b1, '0, '0);
      drv_l(1'b1, 1'b0, 1'b0, 4'd3, 8'hAA);
      tick();
      chk("R2 deselected rdata", m_lrd, 8'h00);
      drv_l(1'b0, 1'b1, 1'b1, 4'd3, 8'h00);
      tick();
      chk("R2 oe high rdata", m_lrd, 8'h00);
      drv_l(1'b0, 1'b0, 1'b1, 4'd3, 8'h00);
      tick();
      chk("R2 deselected write dropped master", m_lrd, ref_m[3]);
      chk("R2 deselected write dropped slave",  s_lrd, ref_s[3]);

      // R6: same-cycle arrival on one address, left wins
      drv_l(1'b1, 1'b1, 1'b1, '0, '0);
      tick();
      drv_l(1'b0, 1'b1, 1'b0, 4'd4, 8'h5A);
      drv_r(1'b0, 1'b1, 1'b0, 4'd4, 8'hA5);
      ref_m[4] = 8'h5A; ref_s[4] = 8'h5A;
      tick();
      busy_chk("R6 tie", 1'b1, 1'b0);
      drv_l(1'b1, 1'b1, 1'b1, '0, '0);
      drv_r(1'b1, 1'b1, 1'b1, '0, '0);
      tick();
      busy_chk("R7 release after tie", 1'b1, 1'b1);
      drv_l(1'b0, 1'b0, 1'b1, 4'd4, '0);
      drv_r(1'b0, 1'b0, 1'b1, 4'd4, '0);
      tick();
      chk("R4 tie master left read",  m_lrd, ref_m[4]);
      chk("R8 tie master right read", m_rrd, ref_m[4]);
      chk("R9 slave same-address left data stored", s_lrd, ref_s[4]);
      busy_chk("R8 shared read busy", 1'b1, 1'b0);
      drv_l(1'b1, 1'b1, 1'b1, '0, '0);
      drv_r(1'b1, 1'b1, 1'b1, '0, '0);
      tick();

      // R5: left early on address 6, right arrives with a write
      drv_l(1'b0, 1'b0, 1'b1, 4'd6, '0);
      tick();
      drv_r(1'b0, 1'b1, 1'b0, 4'd6, 8'h33);
      tick();
      busy_chk("R5 left early", 1'b1, 1'b0);
      chk("R8 winner read proceeds", m_lrd, ref_m[6]);
      ref_s[6] = 8'h33;
      tick();
      busy_chk("R5 owner kept", 1'b1, 1'b0);
      drv_l(1'b1, 1'b1, 1'b1, '0, '0);
      drv_r(1'b1, 1'b1, 1'b1, '0, '0);
      tick();
      busy_chk("R7 release after stagger", 1'b1, 1'b1);
      drv_l(1'b0, 1'b0, 1'b1, 4'd6, '0);
      tick();
      chk("R4 loser write blocked master", m_lrd, ref_m[6]);
      chk("R9 slave write not arbitrated", s_lrd, ref_s[6]);
      drv_l(1'b1, 1'b1, 1'b1, '0, '0);
      tick();

      // R5: right early on address 7, left arrives with a write
      drv_r(1'b0, 1'b0, 1'b1, 4'd7, '0);
      tick();
      drv_l(1'b0, 1'b1, 1'b0, 4'd7, 8'h44);
      tick();
      busy_chk("R5 right early", 1'b0, 1'b1);
      chk("R8 right read proceeds", m_rrd, ref_m[7]);
      ref_s[7] = 8'h44;
      drv_l(1'b1, 1'b1, 1'b1, '0, '0);
      drv_r(1'b1, 1'b1, 1'b1, '0, '0);
      tick();
      busy_chk("R7 release after right early", 1'b1, 1'b1);
      drv_r(1'b0, 1'b0, 1'b1, 4'd7, '0);
      tick();
      chk("R4 left loser blocked master", m_rrd, ref_m[7]);
      chk("R9 slave left write landed",   s_rrd, ref_s[7]);

      // R9/R10: external inhibit on the left port
      l_bin = 1'b0;
      drv_l(1'b0, 1'b1, 1'b0, 4'd9,  8'h77);
      drv_r(1'b0, 1'b1, 1'b0, 4'd10, 8'h88);
      ref_m[9] = 8'h77; ref_m[10] = 8'h88; ref_s[10] = 8'h88;
      tick();
      busy_chk("R9 inhibit busy outputs", 1'b1, 1'b1);
      drv_l(1'b0, 1'b0, 1'b1, 4'd10, '0);
      drv_r(1'b0, 1'b0, 1'b1, 4'd9,  '0);
      tick();
      chk("R9 inhibited port still reads", s_lrd, ref_s[10]);
      chk("R9 inhibited write dropped",    s_rrd, ref_s[9]);
      chk("R10 master ignores inhibit left",  m_rrd, ref_m[9]);
      chk("R10 master right write",           m_lrd, ref_m[10]);
      l_bin = 1'b1;
      drv_l(1'b1, 1'b1, 1'b1, '0, '0);
      drv_r(1'b1, 1'b1, 1'b1, '0, '0);
      tick();

      summary();
      $finish;
   end
endmodule